// File: doc/BRIEF.md
# Opcode Register Access Engine

This block sits behind the byte-level side of an I2C target. It turns framed write and read transfers into accesses on an 8-bit register file. The bit-level target handles start, stop, acknowledge and clock stretching. It hands this block four kinds of one-cycle strobes: frame start, frame stop, a received byte, and a request for the next byte to send.

Every write frame opens with an opcode byte, followed by a register address byte and then any data bytes. The opcodes do five things:
- plain write of one byte;
- read-modify-write that sets bits;
- read-modify-write that clears bits;
- burst write to rising addresses;
- burst read setup.

A burst read is a two-byte write frame of opcode and address. The read phase that follows, usually after a repeated start, streams bytes from rising addresses. Multi-byte values therefore come out low byte first, from the lower address.

The register file is outside the block. The block drives an asynchronous read address and reads the data back in the same cycle. Writes leave through a registered write port.

Top module: `opreg_access_engine`

## Requirements
- R1: After reset, `reg_we` and `tx_valid` are low and the address pointer is 0, so a read request with no setup returns the register at address 0.
- R2: A frame of opcode 0x08, address A, data D writes D to A. `reg_we` is high for exactly the one cycle that follows the cycle in which D was received.
- R3: Opcode 0x18 writes (old value OR D) to address A.
- R4: Opcode 0x20 writes (old value AND NOT D) to address A.
- R5: A frame with opcode 0x08, 0x18 or 0x20 uses exactly three bytes. Further bytes in the same frame cause no write.
- R6: Opcode 0x28 writes each data byte to A, A+1, A+2 and so on. The pointer steps once per data byte and wraps from 0xFF to 0x00.
- R7: After a frame of opcode 0x30 and address A, each read request returns, one cycle later with `tx_valid` high, the registers A, A+1, A+2 and so on in turn.
- R8: A first byte that is none of the five opcodes causes no write for the rest of the frame, and it leaves the pointer unchanged.
- R9: A stop ends the frame. The next byte is decoded as an opcode, and any pending burst-read setup is dropped.
- R10: A read request with no burst-read setup in force returns the register at the current pointer, and it does not move the pointer.
- R11: A read request issued in the cycle right after a written data byte returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | Start or repeated start seen (strobe) |
| frm_stop | input | 1 | Stop seen (strobe) |
| rx_valid | input | 1 | A received byte is on `rx_byte` (strobe) |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | Target needs the next byte to transmit (strobe) |
| tx_valid | output | 1 | `tx_byte` holds the answer to the previous cycle's request |
| tx_byte | output | 8 | Byte to transmit |
| reg_raddr | output | ADDR_W | Register file read address (the pointer) |
| reg_rdata | input | 8 | Register file read data, same cycle |
| reg_we | output | 1 | Register file write strobe |
| reg_waddr | output | ADDR_W | Register file write address |
| reg_wdata | output | 8 | Register file write data |

## Verification
A corrupted frame phase or opcode state shows up at the register write port on the very next data byte. The symptom is a write that should not happen, a missing write, or a wrong merge of old and new bits, and the scoreboard catches it in that same cycle. A pointer that drifts goes unseen until the next write or read. It then appears as a wrong `reg_waddr` or a wrong `tx_byte`, so the bench reads the pointer back after every frame whose effect could otherwise stay hidden. A stale burst-read setup makes two reads with no setup return different bytes, and the bench catches that on the second read.

// File: rtl/opreg_pkg.sv
package opreg_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPC_WRITE  = 8'h08;
    localparam logic [BYTE_W-1:0] OPC_SETB   = 8'h18;
    localparam logic [BYTE_W-1:0] OPC_CLRB   = 8'h20;
    localparam logic [BYTE_W-1:0] OPC_BWRITE = 8'h28;
    localparam logic [BYTE_W-1:0] OPC_BREAD  = 8'h30;

    // Position of the incoming byte inside a write frame
    typedef enum logic [1:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_DATA,
        PH_DROP
    } phase_e;

    // Decoded access kind
    typedef enum logic [2:0] {
        K_NONE,
        K_WRITE,
        K_SET,
        K_CLR,
        K_BWRITE,
        K_BREAD
    } kind_e;

    // A data byte handed from the frame decoder to the write stage
    typedef struct packed {
        logic              fire;
        kind_e             kind;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic kind_e decode_opcode(input logic [BYTE_W-1:0] b);
        case (b)
            OPC_WRITE:  return K_WRITE;
            OPC_SETB:   return K_SET;
            OPC_CLRB:   return K_CLR;
            OPC_BWRITE: return K_BWRITE;
            OPC_BREAD:  return K_BREAD;
            default:    return K_NONE;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] merge_byte(input kind_e k,
                                                     input logic [BYTE_W-1:0] old_v,
                                                     input logic [BYTE_W-1:0] new_v);
        case (k)
            K_SET:   return old_v | new_v;
            K_CLR:   return old_v & ~new_v;
            default: return new_v;
        endcase
    endfunction

endpackage

// File: rtl/opreg_frame_ctl.sv
module opreg_frame_ctl
    import opreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_start,
    input  logic              frm_stop,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output wr_req_t           wreq,
    output logic              ptr_load,
    output logic              ptr_step_wr,
    output logic              rd_armed
);

    phase_e phase_q;
    kind_e  kind_q;
    kind_e  kind_in;
    logic   armed_q;
    logic   accept;

    assign kind_in = decode_opcode(rx_byte);

    // Stop has priority over start, start over a byte in the same cycle
    always_comb begin
        accept      = rx_valid && !frm_start && !frm_stop;
        wreq.fire   = accept && (phase_q == PH_DATA);
        wreq.kind   = kind_q;
        wreq.data   = rx_byte;
        ptr_load    = accept && (phase_q == PH_ADDR);
        ptr_step_wr = wreq.fire && (kind_q == K_BWRITE);
    end

    assign rd_armed = armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_OPCODE;
            kind_q  <= K_NONE;
            armed_q <= 1'b0;
        end else if (frm_stop) begin
            phase_q <= PH_OPCODE;
            kind_q  <= K_NONE;
            armed_q <= 1'b0;
        end else if (frm_start) begin
            phase_q <= PH_OPCODE;
        end else if (rx_valid) begin
            case (phase_q)
                PH_OPCODE: begin
                    kind_q  <= kind_in;
                    armed_q <= 1'b0;
                    phase_q <= (kind_in == K_NONE) ? PH_DROP : PH_ADDR;
                end
                PH_ADDR: begin
                    if (kind_q == K_BREAD) begin
                        armed_q <= 1'b1;
                        phase_q <= PH_DROP;
                    end else begin
                        phase_q <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (kind_q != K_BWRITE)
                        phase_q <= PH_DROP;
                end
                default: ;
            endcase
        end
    end

    // R9: a stop leaves the decoder waiting for an opcode, with no read setup
    p_stop_clears_r9: assert property (@(posedge clk) disable iff (rst)
        frm_stop |=> (phase_q == PH_OPCODE) && !armed_q);

    // R5: a single, set or clear frame closes after its one data byte
    p_three_bytes_r5: assert property (@(posedge clk) disable iff (rst)
        (wreq.fire && (kind_q != K_BWRITE)) |=> (phase_q == PH_DROP));

    // R8: an unknown opcode sends the frame to the drop phase
    p_unknown_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (accept && (phase_q == PH_OPCODE) && (kind_in == K_NONE)) |=> (phase_q == PH_DROP));

endmodule

// File: rtl/opreg_pointer.sv
module opreg_pointer #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);

    localparam logic [ADDR_W-1:0] PTR_ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PTR_LAST = '1;

    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (load)
            ptr_q <= load_val;
        else if (step)
            ptr_q <= ptr_q + PTR_ONE;
    end

    assign ptr = ptr_q;

    // R6: each stepped byte advances the pointer by one
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (ptr_q == $past(ptr_q) + PTR_ONE));

    // R6: stepping from the top address lands on zero
    p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (step && !load && (ptr_q == PTR_LAST)) |=> (ptr_q == '0));

    // R10: the pointer holds when nothing loads or steps it
    p_ptr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(ptr_q));

endmodule

// File: rtl/opreg_write_stage.sv
module opreg_write_stage
    import opreg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wreq,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic [BYTE_W-1:0] cur_val,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_waddr,
    output logic [BYTE_W-1:0] reg_wdata
);

    logic              we_q;
    logic [ADDR_W-1:0] waddr_q;
    logic [BYTE_W-1:0] wdata_q;
    logic              fire;
    logic              fire_set;
    logic              fire_clr;
    logic [BYTE_W-1:0] in_data;

    assign fire     = wreq.fire;
    assign fire_set = wreq.fire && (wreq.kind == K_SET);
    assign fire_clr = wreq.fire && (wreq.kind == K_CLR);
    assign in_data  = wreq.data;

    // A write still in flight to the pointed address wins over the file
    assign cur_val = (we_q && (waddr_q == ptr)) ? wdata_q : reg_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q    <= 1'b0;
            waddr_q <= '0;
            wdata_q <= '0;
        end else begin
            we_q <= fire;
            if (fire) begin
                waddr_q <= ptr;
                wdata_q <= merge_byte(wreq.kind, cur_val, wreq.data);
            end
        end
    end

    assign reg_we    = we_q;
    assign reg_waddr = waddr_q;
    assign reg_wdata = wdata_q;

    // R2: a strobe only ever follows an accepted data byte
    p_we_lag_r2: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> $past(fire));

    // R3: every bit named in a set byte ends up high
    p_set_bits_r3: assert property (@(posedge clk) disable iff (rst)
        $past(fire_set) |-> ((reg_wdata & $past(in_data)) == $past(in_data)));

    // R4: every bit named in a clear byte ends up low
    p_clr_bits_r4: assert property (@(posedge clk) disable iff (rst)
        $past(fire_clr) |-> ((reg_wdata & $past(in_data)) == '0));

endmodule

// File: rtl/opreg_read_stage.sv
module opreg_read_stage
    import opreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic [BYTE_W-1:0] cur_val,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte
);

    logic              valid_q;
    logic [BYTE_W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            byte_q  <= '0;
        end else begin
            valid_q <= rd_req;
            if (rd_req)
                byte_q <= cur_val;
        end
    end

    assign tx_valid = valid_q;
    assign tx_byte  = byte_q;

    // R7: every request is answered in the next cycle and nothing else is
    p_tx_answers_r7: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> tx_valid);

    p_tx_only_asked_r7: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(rd_req));

endmodule

// File: rtl/opreg_access_engine.sv
module opreg_access_engine
    import opreg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_start,
    input  logic              frm_stop,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rd_req,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic [ADDR_W-1:0] reg_raddr,
    input  logic [7:0]        reg_rdata,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_waddr,
    output logic [7:0]        reg_wdata
);

    wr_req_t           wreq;
    logic              ptr_load;
    logic              ptr_step_wr;
    logic              rd_armed;
    logic              ptr_step;
    logic [ADDR_W-1:0] ptr;
    logic [BYTE_W-1:0] cur_val;

    opreg_frame_ctl u_frame (
        .clk         (clk),
        .rst         (rst),
        .frm_start   (frm_start),
        .frm_stop    (frm_stop),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .wreq        (wreq),
        .ptr_load    (ptr_load),
        .ptr_step_wr (ptr_step_wr),
        .rd_armed    (rd_armed)
    );

    // The pointer steps on burst data bytes and on reads after a burst-read setup
    assign ptr_step = ptr_step_wr || (rd_req && rd_armed);

    opreg_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (rx_byte[ADDR_W-1:0]),
        .step     (ptr_step),
        .ptr      (ptr)
    );

    assign reg_raddr = ptr;

    opreg_write_stage #(.ADDR_W(ADDR_W)) u_wr (
        .clk       (clk),
        .rst       (rst),
        .wreq      (wreq),
        .ptr       (ptr),
        .reg_rdata (reg_rdata),
        .cur_val   (cur_val),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata)
    );

    opreg_read_stage u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (rd_req),
        .cur_val  (cur_val),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte)
    );

    // R10: a read with no burst-read setup leaves the pointer where it was
    p_unarmed_read_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_armed && !rx_valid) |=> $stable(reg_raddr));

endmodule

// File: tb/test_opreg_access_engine.sv
module test_opreg_access_engine;

    logic       clk = 1'b0;
    logic       rst;
    logic       frm_start, frm_stop, rx_valid, rd_req;
    logic [7:0] rx_byte;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic [7:0] reg_raddr, reg_waddr, reg_wdata, reg_rdata;
    logic       reg_we;

    always #10 clk = ~clk;   // 50 MHz

    opreg_access_engine #(.ADDR_W(8)) i_opreg_access_engine (
        .clk       (clk),
        .rst       (rst),
        .frm_start (frm_start),
        .frm_stop  (frm_stop),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .rd_req    (rd_req),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata)
    );

    // Register file outside the block
    logic [7:0] mem    [256];
    logic [7:0] shadow [256];
    assign reg_rdata = mem[reg_raddr];
    always @(posedge clk) if (reg_we) mem[reg_waddr] <= reg_wdata;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    typedef struct {
        logic [7:0] addr;
        logic [7:0] data;
        int         at;
        string      req;
    } exp_t;

    exp_t wq[$];
    exp_t rq[$];

    // Model of the frame, derived from the requirements
    int         m_phase = 0;   // 0 opcode, 1 address, 2 data, 3 drop
    logic [7:0] m_op    = 8'h00;
    logic [7:0] m_ptr   = 8'h00;
    bit         m_arm   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_opcode(input logic [7:0] b);
        return (b == 8'h08) || (b == 8'h18) || (b == 8'h20) ||
               (b == 8'h28) || (b == 8'h30);
    endfunction

    task automatic send_byte(input logic [7:0] b, input string req);
        logic [7:0] nv;
        case (m_phase)
            0: begin
                m_op    = b;
                m_arm   = 1'b0;
                m_phase = is_opcode(b) ? 1 : 3;
            end
            1: begin
                m_ptr = b;
                if (m_op == 8'h30) begin
                    m_arm   = 1'b1;
                    m_phase = 3;
                end else begin
                    m_phase = 2;
                end
            end
            2: begin
                if (m_op == 8'h18)      nv = shadow[m_ptr] | b;
                else if (m_op == 8'h20) nv = shadow[m_ptr] & ~b;
                else                    nv = b;
                shadow[m_ptr] = nv;
                wq.push_back('{addr: m_ptr, data: nv, at: cyc + 1, req: req});
                if (m_op == 8'h28) m_ptr = m_ptr + 8'h01;
                else               m_phase = 3;
            end
            default: ;
        endcase
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic read_byte(input string req);
        rq.push_back('{addr: m_ptr, data: shadow[m_ptr], at: cyc + 1, req: req});
        if (m_arm) m_ptr = m_ptr + 8'h01;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic do_start();
        m_phase   = 0;
        frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0;
    endtask

    task automatic do_stop();
        m_phase  = 0;
        m_arm    = 1'b0;
        m_op     = 8'h00;
        frm_stop = 1'b1;
        @(negedge clk);
        frm_stop = 1'b0;
    endtask

    // Monitor: pops the scoreboard as results leave the design
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (reg_we) begin
                if (wq.size() == 0) begin
                    chk(1'b0, "R2/R5/R8", "unexpected write addr", int'(reg_waddr), -1);
                end else begin
                    exp_t e;
                    e = wq.pop_front();
                    chk(reg_waddr == e.addr, e.req, "write addr", int'(reg_waddr), int'(e.addr));
                    chk(reg_wdata == e.data, e.req, "write data", int'(reg_wdata), int'(e.data));
                    chk(cyc == e.at, e.req, "write cycle", cyc, e.at);
                end
            end
            if (tx_valid) begin
                if (rq.size() == 0) begin
                    chk(1'b0, "R7", "unexpected tx byte", int'(tx_byte), -1);
                end else begin
                    exp_t e;
                    e = rq.pop_front();
                    chk(tx_byte == e.data, e.req, "read data", int'(tx_byte), int'(e.data));
                    chk(cyc == e.at, e.req, "read cycle", cyc, e.at);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog all-R actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 8'((i * 7) + 3);
            shadow[i] = 8'((i * 7) + 3);
        end
        rst = 1'b1; frm_start = 1'b0; frm_stop = 1'b0;
        rx_valid = 1'b0; rx_byte = 8'h00; rd_req = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: quiet outputs and pointer at zero after reset
        chk(reg_we == 1'b0, "R1", "reg_we after reset", int'(reg_we), 0);
        chk(tx_valid == 1'b0, "R1", "tx_valid after reset", int'(tx_valid), 0);
        chk(reg_raddr == 8'h00, "R1", "pointer after reset", int'(reg_raddr), 0);
        read_byte("R1");
        read_byte("R10");

        // R2: single write, then R10 read at the last pointer
        do_start(); send_byte(8'h08, "R2"); send_byte(8'h10, "R2"); send_byte(8'hA5, "R2"); do_stop();
        read_byte("R10");

        // R3: set bits  (A5 | 0F = AF)
        do_start(); send_byte(8'h18, "R3"); send_byte(8'h10, "R3"); send_byte(8'h0F, "R3"); do_stop();
        // R4: clear bits (AF & ~81 = 2E)
        do_start(); send_byte(8'h20, "R4"); send_byte(8'h10, "R4"); send_byte(8'h81, "R4"); do_stop();
        read_byte("R4");

        // R5: extra bytes after a single write are dropped
        do_start(); send_byte(8'h08, "R5"); send_byte(8'h20, "R5");
        send_byte(8'h11, "R5"); send_byte(8'h22, "R5"); send_byte(8'h33, "R5"); do_stop();
        read_byte("R5");

        // R6: burst write, pointer ends one past the last byte
        do_start(); send_byte(8'h28, "R6"); send_byte(8'h40, "R6");
        send_byte(8'h01, "R6"); send_byte(8'h02, "R6"); send_byte(8'h03, "R6"); send_byte(8'h04, "R6");
        do_stop();
        read_byte("R6");

        // R6: burst write wrapping over the top address
        do_start(); send_byte(8'h28, "R6"); send_byte(8'hFE, "R6");
        send_byte(8'hAA, "R6"); send_byte(8'hBB, "R6"); send_byte(8'hCC, "R6"); do_stop();
        read_byte("R6");

        // R7: burst read setup, repeated start, four reads (low byte first)
        do_start(); send_byte(8'h30, "R7"); send_byte(8'h40, "R7");
        do_start();
        read_byte("R7"); read_byte("R7"); read_byte("R7"); read_byte("R7");
        do_stop();
        // R9: setup dropped by stop, so two reads give the same byte
        read_byte("R9"); read_byte("R9");

        // R8: unknown opcode writes nothing and keeps the pointer
        do_start(); send_byte(8'h55, "R8"); send_byte(8'h70, "R8"); send_byte(8'h99, "R8"); do_stop();
        read_byte("R8");

        // R9: stop mid-frame, then the next byte is an opcode again
        do_start(); send_byte(8'h08, "R9"); send_byte(8'h50, "R9"); do_stop();
        send_byte(8'h08, "R9"); send_byte(8'h51, "R9"); send_byte(8'h77, "R9"); do_stop();
        read_byte("R9");

        // R11: a read right after the data byte sees the new value
        do_start(); send_byte(8'h08, "R11"); send_byte(8'h60, "R11"); send_byte(8'h5A, "R11");
        read_byte("R11");
        do_stop();

        repeat (4) @(negedge clk);
        chk(wq.size() == 0, "R2", "writes never seen", wq.size(), 0);
        chk(rq.size() == 0, "R7", "reads never answered", rq.size(), 0);
        for (int i = 0; i < 256; i++)
            if (mem[i] != shadow[i])
                chk(1'b0, "R8", $sformatf("register %0h content", i), int'(mem[i]), int'(shadow[i]));
        chk(1'b1, "R5", "register file compared", 0, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule